// File: doc/BRIEF.md
# UART Register Front End with Receive and Transmit Queues

This block is the software-facing half of a simple serial port. A single-cycle register port lets a processor write characters into a transmit queue, read characters from a receive queue, and poll a flag word that reports whether the queues are full, empty or still draining. Two configuration registers hold the line settings and the enables. A separate clear register resets the accumulated receive error record.

On the serial side, the block offers the head of the transmit queue to an external shifter through a valid/take pair. It accepts received characters from an external deserializer, each with framing, parity and break indications. Every received character is stored with its own error bits, so a data read returns the character in its low byte and the error status of that character directly above it. The shifters and the baud generator sit outside this block.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the flag word (address 1) reads 0x0006: bit 0 transmit-full is 0, bit 1 receive-empty is 1, bit 2 transmit-empty is 1 and bit 3 busy is 0. The line register (address 3) reads 0, and the enable and request-to-send outputs are 0.
- R2: A write to address 0 appends bits 7:0 to the transmit queue. The queue head appears on `txByte`, and `txValid` is high only while the queue is non-empty and both the global enable and the transmit enable are set. A cycle with `txValid` and `txTake` both high removes the head, so bytes leave in write order.
- R3: Transmit-full (flag bit 0) is set when the queue holds as many bytes as its capacity. A data write while it is set is discarded and leaves the queue contents unchanged.
- R4: Busy (flag bit 3) is set while the transmit queue is non-empty or `txShifting` is high.
- R5: When the global enable and the receive enable are both set, a `rxStrobe` stores `rxByte` together with its error bits. A read of address 0 returns the oldest stored entry and removes it. Receive-empty (flag bit 1) is clear while an entry is stored.
- R6: A read of address 0 while the receive queue is empty returns 0 and removes nothing.
- R7: A `rxStrobe` that arrives while the receive queue is full is dropped. It sets error-status bit 3, and the next stored character carries bit 11 (overrun) in its data read.
- R8: In a data read, bit 8 is framing (`rxErr[0]`), bit 9 is parity (`rxErr[1]`) and bit 10 is break (`rxErr[2]`). The error-status register (address 5) accumulates these conditions in bits 0, 1 and 2, with overrun in bit 3.
- R9: Any write to address 2 sets the error-status register to 0.
- R10: The control register (address 4) has bit 0 as global enable, bit 1 as transmit enable, bit 2 as receive enable and bit 3 as request-to-send, each driven on its own output pin. Writing 0 turns them all off. While the receive path is disabled, `rxStrobe` is ignored.
- R11: The line register has bit 0 as queue enable and bits 2:1 as the word-length code, driven on `wordLen` (code 3 selects 8 bits). With the queue enable clear, each queue holds a single entry. With it set, each queue holds `FIFO_DEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (a data read pops at the clock edge) |
| busAddr | input | 3 | Register select |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, valid in the cycle of the read |
| txByte | output | 8 | Transmit queue head |
| txValid | output | 1 | Head is offered to the transmit shifter |
| txTake | input | 1 | Transmit shifter accepts the head |
| txShifting | input | 1 | Transmit shifter is still sending a character |
| rxByte | input | 8 | Received character |
| rxErr | input | 3 | Break, parity, framing of the received character |
| rxStrobe | input | 1 | Received character is present this cycle |
| uartEnable | output | 1 | Global enable |
| txEnable | output | 1 | Transmit enable |
| rxEnable | output | 1 | Receive enable |
| rtsOut | output | 1 | Request-to-send |
| wordLen | output | 2 | Word-length code |

## Verification
Register reads are combinational, so their data is due in the same cycle as the read strobe. Writes, pushes, pops and error updates take effect at the next rising edge, and the transmit head and `txValid` change right after that edge. The bench changes inputs on falling edges and samples read data 1 ns after it asserts the strobe, before the edge that commits a pop. It samples all other results 1 ns after the rising edge that registers the stimulus. Queue order, capacity with the queue enable on and off, and all eight receive error patterns are covered by sweeps whose expected values are computed from the loop indices.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  localparam int ADDR_W = 3;
  localparam int BUS_W  = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 3'd0,
    REG_FLAGS   = 3'd1,
    REG_ERRCLR  = 3'd2,
    REG_LINE    = 3'd3,
    REG_CTRL    = 3'd4,
    REG_ERRSTAT = 3'd5
  } regSel_e;

  localparam int FLAG_TXFULL  = 0;
  localparam int FLAG_RXEMPTY = 1;
  localparam int FLAG_TXEMPTY = 2;
  localparam int FLAG_BUSY    = 3;

  localparam int ERR_W   = 4;
  localparam int ENTRY_W = 8 + ERR_W;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic lineWr;
    logic ctrlWr;
    logic errClr;
    logic overDrop;
  } strobes_t;

  typedef struct packed {
    logic txFull;
    logic txEmpty;
    logic rxFull;
    logic rxEmpty;
    logic txOn;
    logic rxOn;
  } status_t;

endpackage

// File: rtl/uart_reg_fifo.sv
module uart_reg_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 12,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] limit,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count >= limit);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
(
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              txTake,
  input  logic              rxStrobe,
  input  status_t           status,
  output strobes_t          strobes
);

  logic selData;
  logic rxArrive;

  assign selData  = (busAddr == REG_DATA);
  assign rxArrive = rxStrobe && status.rxOn;

  always_comb begin
    strobes          = '0;
    strobes.txPush   = busWrEn && selData && !status.txFull;
    strobes.txPop    = txTake && status.txOn && !status.txEmpty;
    strobes.rxPop    = busRdEn && selData && !status.rxEmpty;
    strobes.rxPush   = rxArrive && !status.rxFull;
    strobes.overDrop = rxArrive && status.rxFull;
    strobes.lineWr   = busWrEn && (busAddr == REG_LINE);
    strobes.ctrlWr   = busWrEn && (busAddr == REG_CTRL);
    strobes.errClr   = busWrEn && (busAddr == REG_ERRCLR);
  end

endmodule

// File: rtl/uart_reg_datapath.sv
module uart_reg_datapath
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              txShifting,
  input  logic [7:0]        rxByte,
  input  logic [2:0]        rxErr,
  output logic [7:0]        txByte,
  output logic              txValid,
  output status_t           status,
  output logic [3:0]        ctrlBits,
  output logic [1:0]        wordLen
);

  logic [3:0]       ctrlReg;
  logic [2:0]       lineReg;
  logic [ERR_W-1:0] stickyErr;
  logic             pendOverrun;
  logic [CNT_W-1:0] fifoLimit;
  logic [ENTRY_W-1:0] rxIn, rxHead;
  logic [7:0]       txHead;
  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic [3:0]       flags;
  logic             unusedWrBits;

  assign unusedWrBits = ^busWrData[BUS_W-1:4];
  assign fifoLimit = lineReg[0] ? CNT_W'(DEPTH) : CNT_W'(1);
  assign rxIn      = {pendOverrun, rxErr, rxByte};

  uart_reg_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txFifo (
    .clk(clk), .rst_n(rst_n), .push(strobes.txPush), .pop(strobes.txPop),
    .limit(fifoLimit), .wrData(busWrData[7:0]), .rdData(txHead),
    .full(txFull), .empty(txEmpty)
  );

  uart_reg_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_rxFifo (
    .clk(clk), .rst_n(rst_n), .push(strobes.rxPush), .pop(strobes.rxPop),
    .limit(fifoLimit), .wrData(rxIn), .rdData(rxHead),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg     <= '0;
      lineReg     <= '0;
      stickyErr   <= '0;
      pendOverrun <= 1'b0;
    end else begin
      if (strobes.ctrlWr) ctrlReg <= busWrData[3:0];
      if (strobes.lineWr) lineReg <= busWrData[2:0];
      stickyErr <= (strobes.errClr ? '0 : stickyErr)
                 | (strobes.rxPush ? rxIn[ENTRY_W-1:8] : '0)
                 | (strobes.overDrop ? 4'b1000 : 4'b0000);
      if (strobes.overDrop)    pendOverrun <= 1'b1;
      else if (strobes.rxPush) pendOverrun <= 1'b0;
    end
  end

  always_comb begin
    status         = '0;
    status.txFull  = txFull;
    status.txEmpty = txEmpty;
    status.rxFull  = rxFull;
    status.rxEmpty = rxEmpty;
    status.txOn    = ctrlReg[0] && ctrlReg[1];
    status.rxOn    = ctrlReg[0] && ctrlReg[2];
  end

  always_comb begin
    flags               = '0;
    flags[FLAG_TXFULL]  = txFull;
    flags[FLAG_RXEMPTY] = rxEmpty;
    flags[FLAG_TXEMPTY] = txEmpty;
    flags[FLAG_BUSY]    = !txEmpty || txShifting;
  end

  always_comb begin
    case (busAddr)
      REG_DATA:    busRdData = rxEmpty ? '0 : BUS_W'(rxHead);
      REG_FLAGS:   busRdData = BUS_W'(flags);
      REG_LINE:    busRdData = BUS_W'(lineReg);
      REG_CTRL:    busRdData = BUS_W'(ctrlReg);
      REG_ERRSTAT: busRdData = BUS_W'(stickyErr);
      default:     busRdData = '0;
    endcase
  end

  assign txByte   = txHead;
  assign txValid  = status.txOn && !txEmpty;
  assign ctrlBits = ctrlReg;
  assign wordLen  = lineReg[2:1];

endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic [7:0]        txByte,
  output logic              txValid,
  input  logic              txTake,
  input  logic              txShifting,
  input  logic [7:0]        rxByte,
  input  logic [2:0]        rxErr,
  input  logic              rxStrobe,
  output logic              uartEnable,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              rtsOut,
  output logic [1:0]        wordLen
);

  strobes_t   strobes;
  status_t    status;
  logic [3:0] ctrlBits;

  uart_reg_ctrl u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .txTake(txTake), .rxStrobe(rxStrobe), .status(status), .strobes(strobes)
  );

  uart_reg_datapath #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .txShifting(txShifting),
    .rxByte(rxByte), .rxErr(rxErr), .txByte(txByte), .txValid(txValid),
    .status(status), .ctrlBits(ctrlBits), .wordLen(wordLen)
  );

  assign uartEnable = ctrlBits[0];
  assign txEnable   = ctrlBits[1];
  assign rxEnable   = ctrlBits[2];
  assign rtsOut     = ctrlBits[3];

endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk
  import uart_reg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busRdData,
  input logic [7:0]        txByte,
  input logic              txValid,
  input logic              txTake,
  input logic              rxStrobe,
  input logic              uartEnable,
  input logic              txEnable,
  input status_t           status
);

  // R2: the shifter is offered a byte only with both enables set
  assert_txvalid_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |-> (uartEnable && txEnable));

  // R3: a write into a full queue with no removal changes nothing
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == REG_DATA && status.txFull && !(txValid && txTake))
      |=> (status.txFull && $stable(txByte)));

  // R4: a non-empty transmit queue always reports busy
  assert_busy_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busAddr == REG_FLAGS && !status.txEmpty) |-> busRdData[FLAG_BUSY]);

  // R6: reading an empty receive queue yields zero
  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busAddr == REG_DATA && status.rxEmpty) |-> (busRdData == '0));

  // R9: the error record is empty right after a clear write
  assert_errclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == REG_ERRCLR && !rxStrobe) ##1 (busRdEn && busAddr == REG_ERRSTAT)
      |-> (busRdData[3:0] == 4'd0));

endmodule

bind uart_reg_front uart_reg_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busRdData(busRdData), .txByte(txByte), .txValid(txValid),
  .txTake(txTake), .rxStrobe(rxStrobe), .uartEnable(uartEnable),
  .txEnable(txEnable), .status(status)
);

// File: tb/uart_reg_front_bench.sv
`timescale 1ns/1ps
module uart_reg_front_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [7:0]  txByte;
  logic        txValid;
  logic        txTake = 1'b0, txShifting = 1'b0;
  logic [7:0]  rxByte = '0;
  logic [2:0]  rxErr = '0;
  logic        rxStrobe = 1'b0;
  logic        uartEnable, txEnable, rxEnable, rtsOut;
  logic [1:0]  wordLen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_reg_front #(.FIFO_DEPTH(DEPTH)) u_uart_reg_front (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .txByte(txByte), .txValid(txValid), .txTake(txTake), .txShifting(txShifting),
    .rxByte(rxByte), .rxErr(rxErr), .rxStrobe(rxStrobe),
    .uartEnable(uartEnable), .txEnable(txEnable), .rxEnable(rxEnable),
    .rtsOut(rtsOut), .wordLen(wordLen)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    txTake = 1'b1;
    @(posedge clk); #1;
    txTake = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] b, input logic [2:0] e);
    @(negedge clk);
    rxStrobe = 1'b1; rxByte = b; rxErr = e;
    @(posedge clk); #1;
    rxStrobe = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    busRead(3'd1, rd); check("R1 flags", rd, 16'h0006);
    busRead(3'd3, rd); check("R1 line", rd, 16'h0000);
    check("R1 outputs", {12'd0, rtsOut, rxEnable, txEnable, uartEnable}, 16'h0000);

    // R10 control bits drive pins
    busWrite(3'd4, 16'h000F);
    check("R10 pins on", {12'd0, rtsOut, rxEnable, txEnable, uartEnable}, 16'h000F);

    // R11 queue disabled: single-entry transmit holding register
    busWrite(3'd0, 16'h00A1);
    busRead(3'd1, rd); check("R11 single entry full", {15'd0, rd[0]}, 16'd1);
    busWrite(3'd0, 16'h00B2);
    check("R3 drop when full", {8'd0, txByte}, 16'h00A1);
    take();
    check("R2 pop empties", {15'd0, txValid}, 16'd0);

    // R4 busy follows shifter
    @(negedge clk) txShifting = 1'b1;
    busRead(3'd1, rd); check("R4 busy shifting", {15'd0, rd[3]}, 16'd1);
    @(negedge clk) txShifting = 1'b0;
    busRead(3'd1, rd); check("R4 idle", {15'd0, rd[3]}, 16'd0);

    // R11 queue enable and word length
    busWrite(3'd3, 16'h0007);
    busRead(3'd3, rd); check("R11 line readback", rd, 16'h0007);
    check("R11 wordLen", {14'd0, wordLen}, 16'h0003);

    // R2/R3 sweep over fill levels
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) busWrite(3'd0, 16'(n * 16 + i));
      busRead(3'd1, rd);
      check("R3 full at capacity", {15'd0, rd[0]}, {15'd0, n == DEPTH});
      check("R4 busy with data", {15'd0, rd[3]}, 16'd1);
      if (n == DEPTH) busWrite(3'd0, 16'h00EE);
      for (int i = 0; i < n; i++) begin
        check("R2 order", {7'd0, txValid, txByte}, {7'd0, 1'b1, 8'(n * 16 + i)});
        take();
      end
      busRead(3'd1, rd); check("R2 drained", rd, 16'h0006);
    end

    // R2 transmit enable gating
    busWrite(3'd4, 16'h0001);
    busWrite(3'd0, 16'h0033);
    check("R2 gated off", {15'd0, txValid}, 16'd0);
    busWrite(3'd4, 16'h0003);
    check("R2 gated on", {7'd0, txValid, txByte}, 16'h0133);
    take();

    // R6 empty read, then R5 single byte
    busWrite(3'd4, 16'h0005);
    busRead(3'd0, rd); check("R6 empty read zero", rd, 16'h0000);
    busRead(3'd1, rd); check("R6 still empty", {15'd0, rd[1]}, 16'd1);
    rxSend(8'h5A, 3'd0);
    busRead(3'd1, rd); check("R5 not empty", {15'd0, rd[1]}, 16'd0);
    busRead(3'd0, rd); check("R5 data", rd, 16'h005A);
    busRead(3'd1, rd); check("R5 empty after pop", {15'd0, rd[1]}, 16'd1);

    // R8/R9 error pattern sweep
    for (int e = 0; e < 8; e++) begin
      busWrite(3'd2, 16'hFFFF);
      busRead(3'd5, rd); check("R9 cleared", rd, 16'h0000);
      rxSend(8'(8'hA0 + e), 3'(e));
      busRead(3'd0, rd); check("R8 data with errors", rd, 16'((e << 8) | (8'hA0 + e)));
      busRead(3'd5, rd); check("R8 sticky", rd, 16'(e));
    end
    busWrite(3'd2, 16'h0000);

    // R7 overrun
    for (int i = 0; i < DEPTH; i++) rxSend(8'(8'h40 + i), 3'd0);
    rxSend(8'hFF, 3'd0);
    busRead(3'd5, rd); check("R7 overrun sticky", rd, 16'h0008);
    for (int i = 0; i < DEPTH; i++) begin
      busRead(3'd0, rd); check("R7 kept bytes", rd, 16'(8'h40 + i));
    end
    busRead(3'd1, rd); check("R7 dropped byte absent", {15'd0, rd[1]}, 16'd1);
    rxSend(8'h55, 3'd0);
    busRead(3'd0, rd); check("R7 overrun tag", rd, 16'h0855);
    rxSend(8'h56, 3'd0);
    busRead(3'd0, rd); check("R7 tag once", rd, 16'h0056);

    // R10 write zero disables everything, rx ignored
    busWrite(3'd4, 16'h0000);
    check("R10 pins off", {12'd0, rtsOut, rxEnable, txEnable, uartEnable}, 16'h0000);
    busWrite(3'd0, 16'h0077);
    check("R10 tx held", {15'd0, txValid}, 16'd0);
    rxSend(8'h99, 3'd0);
    busRead(3'd1, rd); check("R10 rx ignored", {15'd0, rd[1]}, 16'd1);
    busRead(3'd0, rd); check("R10 nothing stored", rd, 16'h0000);

    done = 1;
    summary();
  end

endmodule